// File: doc/BRIEF.md
# Memory Bank Address Decoder

This block maps a 32-bit physical address onto one of eight programmable memory banks. Every bank has a lower and an upper limit. Software sets each limit through two fields: a 2-bit extension and an 8-bit base. The block builds the full limit from those two fields plus a fixed 20-bit tail, so the limits have a granularity of 1 MB. A one-byte enable register switches each bank on or off. A bank that is switched off never matches, whatever range it holds.

The address is captured at one clock edge and decoded combinationally. The decode results are registered at the next edge. The outputs are:
- a one-hot bank select,
- a hit flag,
- the encoded bank number,
- an overlap flag, set when more than one enabled bank claims the address,
- a sticky configuration-error flag, set when an enabled bank has its end limit below its start limit.

Configuration arrives through a simple write port. The port addresses a field by a select code and a bank number.

Top module: `membank_decode`

## Requirements
- R1: While `rst_n` is low, and after it is released, all outputs are 0. All fields and the enable byte reset to 0, so every bank starts disabled.
- R2: The lower limit of bank n is `{2'b00, start_ext[1:0], start[7:0], 20'h00000}`. The comparison is unsigned and inclusive, so the address equal to the lower limit hits and the address one below it does not.
- R3: The upper limit of bank n is `{2'b00, end_ext[1:0], end[7:0], 20'hFFFFF}`, and the comparison is inclusive. With start=0x00, end=0x3F and both extensions 0, the bank covers 0x0000_0000 through 0x03FF_FFFF, and 0x0400_0000 misses.
- R4: An address with bit 31 or bit 30 set never hits any bank.
- R5: A bank whose enable bit is 0 is never selected, even when its range overlaps the address or another enabled bank.
- R6: When several enabled banks match, the lowest-numbered bank wins. `bank_sel_o` is one-hot with the winner's bit set, and `bank_idx_o` holds its number.
- R7: `overlap_o` is 1 exactly when two or more enabled banks match the decoded address.
- R8: `hit_o` is 1 exactly when some enabled bank matches. On a miss, `bank_sel_o`, `bank_idx_o` and `overlap_o` are all 0.
- R9: An address present before clock edge k is captured at edge k. Its decode results appear after edge k+1, and the outputs before that edge still show the previous address.
- R10: `cfg_err_o` becomes 1 when an enabled bank has `{end_ext,end}` < `{start_ext,start}`, and it stays at 1. A bank that is disabled with such a range does not set it.
- R11: A write to the enable byte clears `cfg_err_o`; it is set again afterwards if an enabled bank is still inverted. A write to any other field leaves it unchanged.
- R12: When `cfg_we_i`=1 at an edge, `cfg_wdata_i` is written to the field chosen by `cfg_sel_i`:
  - 0: start base of bank `cfg_bank_i`
  - 1: start extension, `cfg_wdata_i[1:0]`
  - 2: end base
  - 3: end extension, `cfg_wdata_i[1:0]`
  - 4: the enable byte, where bit n enables bank n and `cfg_bank_i` is ignored
  - 5 to 7: no field is written

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Field select code (R12) |
| cfg_bank_i | input | 3 | Bank number for per-bank fields |
| cfg_wdata_i | input | 8 | Write data |
| addr_i | input | 32 | Physical address to decode |
| bank_sel_o | output | 8 | One-hot selected bank |
| hit_o | output | 1 | Some enabled bank matched |
| bank_idx_o | output | 3 | Number of the selected bank |
| overlap_o | output | 1 | Two or more enabled banks matched |
| cfg_err_o | output | 1 | Sticky inverted-range error |

## Verification
The bench probes both edges of a range, built with extension bits set: the first and last address inside, and one MB step outside. An off-by-one in the tail fill or a wrong field order would shift or shrink the window at these points. It places a disabled bank over an enabled one and also over an otherwise unmapped address. A decoder that ignores the enable bit would then report a hit or the wrong winner. Stacked enabled banks test the lowest-number priority and the overlap flag, where a reversed scan would name the higher bank. The sticky error is driven through set, survives a non-enable write, and is then cleared, which catches a flag that is combinational or clears on the wrong write. A step-by-step latency probe catches one register too many or too few on the path.

// File: rtl/membank_pkg.sv
package membank_pkg;

    // Field select codes on the configuration write port
    typedef enum logic [2:0] {
        FLD_START     = 3'd0,
        FLD_START_EXT = 3'd1,
        FLD_END       = 3'd2,
        FLD_END_EXT   = 3'd3,
        FLD_ENABLE    = 3'd4
    } cfg_field_e;

endpackage

// File: rtl/membank_cfg_regs.sv
module membank_cfg_regs
    import membank_pkg::*;
#(
    parameter int NB      = 8,
    parameter int FIELD_W = 8,
    parameter int EXT_W   = 2,
    parameter int BANK_W  = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we_i,
    input  logic [2:0]                     sel_i,
    input  logic [BANK_W-1:0]              bank_i,
    input  logic [FIELD_W-1:0]             wdata_i,
    output logic [NB-1:0][FIELD_W-1:0]     start_o,
    output logic [NB-1:0][EXT_W-1:0]       start_ext_o,
    output logic [NB-1:0][FIELD_W-1:0]     end_o,
    output logic [NB-1:0][EXT_W-1:0]       end_ext_o,
    output logic [NB-1:0]                  en_o,
    output logic                           en_wr_o
);

    typedef struct packed {
        logic [NB-1:0][FIELD_W-1:0] st;
        logic [NB-1:0][EXT_W-1:0]   sx;
        logic [NB-1:0][FIELD_W-1:0] nd;
        logic [NB-1:0][EXT_W-1:0]   nx;
        logic [NB-1:0]              en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (cfg_field_e'(sel_i))
                FLD_START:     cfg_d.st[bank_i] = wdata_i;
                FLD_START_EXT: cfg_d.sx[bank_i] = wdata_i[EXT_W-1:0];
                FLD_END:       cfg_d.nd[bank_i] = wdata_i;
                FLD_END_EXT:   cfg_d.nx[bank_i] = wdata_i[EXT_W-1:0];
                FLD_ENABLE:    cfg_d.en         = wdata_i[NB-1:0];
                default:       cfg_d            = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign start_o     = cfg_q.st;
    assign start_ext_o = cfg_q.sx;
    assign end_o       = cfg_q.nd;
    assign end_ext_o   = cfg_q.nx;
    assign en_o        = cfg_q.en;
    assign en_wr_o     = we_i && (sel_i == FLD_ENABLE);

    // R12
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == FLD_ENABLE) |=> (en_o == $past(wdata_i[NB-1:0])));

    // R12
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i > 3'd4) |=> $stable(cfg_q));

endmodule

// File: rtl/membank_bank_match.sv
module membank_bank_match #(
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 8,
    parameter int EXT_W   = 2,
    parameter int TAIL_W  = 20
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [FIELD_W-1:0] start_i,
    input  logic [EXT_W-1:0]   start_ext_i,
    input  logic [FIELD_W-1:0] end_i,
    input  logic [EXT_W-1:0]   end_ext_i,
    input  logic               en_i,
    output logic               match_o,
    output logic               bad_o
);

    localparam int PAD_W = ADDR_W - EXT_W - FIELD_W - TAIL_W;

    logic [ADDR_W-1:0] lower, upper;

    assign lower = {{PAD_W{1'b0}}, start_ext_i, start_i, {TAIL_W{1'b0}}};
    assign upper = {{PAD_W{1'b0}}, end_ext_i,   end_i,   {TAIL_W{1'b1}}};

    assign match_o = en_i && (addr_i >= lower) && (addr_i <= upper);
    assign bad_o   = en_i && ({end_ext_i, end_i} < {start_ext_i, start_i});

endmodule

// File: rtl/membank_prio.sv
module membank_prio #(
    parameter int NB     = 8,
    parameter int BANK_W = 3
) (
    input  logic [NB-1:0]     req_i,
    output logic [NB-1:0]     gnt_o,
    output logic [BANK_W-1:0] idx_o,
    output logic              any_o,
    output logic              multi_o
);

    logic [BANK_W:0] cnt;

    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
                idx_o    = BANK_W'(i);
            end
        end
    end

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NB; i++) begin
            cnt = cnt + {{BANK_W{1'b0}}, req_i[i]};
        end
    end

    assign any_o   = (cnt != '0);
    assign multi_o = (cnt > 1);

endmodule

// File: rtl/membank_decode.sv
module membank_decode
    import membank_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NB      = 8,
    parameter int FIELD_W = 8,
    parameter int EXT_W   = 2,
    parameter int TAIL_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_sel_i,
    input  logic [2:0]        cfg_bank_i,
    input  logic [7:0]        cfg_wdata_i,
    input  logic [31:0]       addr_i,
    output logic [7:0]        bank_sel_o,
    output logic              hit_o,
    output logic [2:0]        bank_idx_o,
    output logic              overlap_o,
    output logic              cfg_err_o
);

    localparam int BANK_W = $clog2(NB);

    logic [NB-1:0][FIELD_W-1:0] st, nd;
    logic [NB-1:0][EXT_W-1:0]   sx, nx;
    logic [NB-1:0]              en;
    logic                       en_wr;
    logic [NB-1:0]              match, bad;
    logic [NB-1:0]              gnt;
    logic [BANK_W-1:0]          idx;
    logic                       any, multi;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [NB-1:0]     sel;
        logic              hit;
        logic [BANK_W-1:0] idx;
        logic              ovl;
        logic              err;
    } state_t;

    state_t s_d, s_q;

    membank_cfg_regs #(
        .NB(NB), .FIELD_W(FIELD_W), .EXT_W(EXT_W), .BANK_W(BANK_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we_i(cfg_we_i), .sel_i(cfg_sel_i), .bank_i(cfg_bank_i),
        .wdata_i(cfg_wdata_i),
        .start_o(st), .start_ext_o(sx), .end_o(nd), .end_ext_o(nx),
        .en_o(en), .en_wr_o(en_wr)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        membank_bank_match #(
            .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .EXT_W(EXT_W), .TAIL_W(TAIL_W)
        ) u_match (
            .addr_i(s_q.addr),
            .start_i(st[b]), .start_ext_i(sx[b]),
            .end_i(nd[b]),   .end_ext_i(nx[b]),
            .en_i(en[b]),
            .match_o(match[b]), .bad_o(bad[b])
        );
    end

    membank_prio #(.NB(NB), .BANK_W(BANK_W)) u_prio (
        .req_i(match), .gnt_o(gnt), .idx_o(idx), .any_o(any), .multi_o(multi)
    );

    always_comb begin
        s_d      = s_q;
        s_d.addr = addr_i;
        s_d.sel  = gnt;
        s_d.hit  = any;
        s_d.idx  = idx;
        s_d.ovl  = multi;
        s_d.err  = en_wr ? 1'b0 : (s_q.err | (|bad));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bank_sel_o = s_q.sel;
    assign hit_o      = s_q.hit;
    assign bank_idx_o = s_q.idx;
    assign overlap_o  = s_q.ovl;
    assign cfg_err_o  = s_q.err;

    // R6
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel_o));

    // R8
    hit_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o == (bank_sel_o != '0));

    // R6
    idx_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> bank_sel_o[bank_idx_o]);

    // R7
    overlap_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_o |-> hit_o);

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (bank_idx_o == '0 && !overlap_o));

    // R5
    disabled_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel_o & ~$past(en)) == '0);

    // R11
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> !cfg_err_o);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err_o && !en_wr) |=> cfg_err_o);

endmodule

// File: tb/sim_membank_decode.sv
module sim_membank_decode;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [2:0]  cfg_sel_i = '0;
    logic [2:0]  cfg_bank_i = '0;
    logic [7:0]  cfg_wdata_i = '0;
    logic [31:0] addr_i = '0;
    logic [7:0]  bank_sel_o;
    logic        hit_o;
    logic [2:0]  bank_idx_o;
    logic        overlap_o;
    logic        cfg_err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_st [8];
    logic [1:0] m_sx [8];
    logic [7:0] m_nd [8];
    logic [1:0] m_nx [8];
    logic [7:0] m_en;

    always #4 clk = ~clk;

    membank_decode u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_bank_i(cfg_bank_i),
        .cfg_wdata_i(cfg_wdata_i), .addr_i(addr_i),
        .bank_sel_o(bank_sel_o), .hit_o(hit_o), .bank_idx_o(bank_idx_o),
        .overlap_o(overlap_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [2:0] bank,
                      input logic [7:0] data);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_bank_i = bank; cfg_wdata_i = data;
        case (sel)
            3'd0: m_st[bank] = data;
            3'd1: m_sx[bank] = data[1:0];
            3'd2: m_nd[bank] = data;
            3'd3: m_nx[bank] = data[1:0];
            3'd4: m_en = data;
            default: ;
        endcase
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic set_bank(input int b, input logic [1:0] sx, input logic [7:0] s,
                            input logic [1:0] nx, input logic [7:0] e);
        wr(3'd0, 3'(b), s);
        wr(3'd1, 3'(b), {6'd0, sx});
        wr(3'd2, 3'(b), e);
        wr(3'd3, 3'(b), {6'd0, nx});
    endtask

    // expected outputs from the requirement formulas (R2, R3, R5..R8)
    task automatic model(input logic [31:0] a, output logic [7:0] sel,
                         output logic hit, output logic [2:0] idx, output logic ovl);
        int n = 0;
        sel = '0; hit = 1'b0; idx = '0;
        for (int b = 0; b < 8; b++) begin
            logic [31:0] lo, hi;
            lo = {2'b00, m_sx[b], m_st[b], 20'h00000};
            hi = {2'b00, m_nx[b], m_nd[b], 20'hFFFFF};
            if (m_en[b] && a >= lo && a <= hi) begin
                n++;
                if (!hit) begin
                    hit = 1'b1; idx = 3'(b); sel[b] = 1'b1;
                end
            end
        end
        ovl = (n > 1);
    endtask

    task automatic look(input string req, input logic [31:0] a,
                        input logic exp_hit, input logic [2:0] exp_idx,
                        input logic exp_ovl);
        logic [7:0] ms; logic mh; logic [2:0] mi; logic mo;
        @(negedge clk); addr_i = a;
        @(negedge clk);
        @(negedge clk);
        model(a, ms, mh, mi, mo);
        chk(req, "hit(spec)", 32'(hit_o), 32'(exp_hit));
        chk(req, "idx(spec)", 32'(bank_idx_o), 32'(exp_idx));
        chk(req, "ovl(spec)", 32'(overlap_o), 32'(exp_ovl));
        chk(req, "sel(model)", 32'(bank_sel_o), 32'(ms));
        chk(req, "hit(model)", 32'(hit_o), 32'(mh));
    endtask

    task automatic t_reset();
        chk("R1", "sel", 32'(bank_sel_o), 0);
        chk("R1", "hit", 32'(hit_o), 0);
        chk("R1", "idx", 32'(bank_idx_o), 0);
        chk("R1", "ovl", 32'(overlap_o), 0);
        chk("R1", "err", 32'(cfg_err_o), 0);
        // all banks disabled after reset: address 0 must miss
        look("R1", 32'h0000_0000, 1'b0, 3'd0, 1'b0);
    endtask

    task automatic t_basic_range();
        set_bank(0, 2'd0, 8'h00, 2'd0, 8'h3F);
        wr(3'd4, 3'd0, 8'h01);
        look("R3", 32'h0000_0000, 1'b1, 3'd0, 1'b0);
        look("R3", 32'h03FF_FFFF, 1'b1, 3'd0, 1'b0);
        look("R3", 32'h0400_0000, 1'b0, 3'd0, 1'b0);
    endtask

    task automatic t_ext_range();
        set_bank(5, 2'd1, 8'h10, 2'd1, 8'h1F);
        wr(3'd4, 3'd0, 8'h21);
        look("R2", 32'h10FF_FFFF, 1'b0, 3'd0, 1'b0);
        look("R2", 32'h1100_0000, 1'b1, 3'd5, 1'b0);
        look("R3", 32'h11FF_FFFF, 1'b1, 3'd5, 1'b0);
        look("R3", 32'h1200_0000, 1'b0, 3'd0, 1'b0);
        look("R4", 32'h5100_0000, 1'b0, 3'd0, 1'b0);
        look("R4", 32'h8000_0000, 1'b0, 3'd0, 1'b0);
    endtask

    task automatic t_disabled();
        // bank 1 spans everything below 0x1000_0000 but stays disabled
        set_bank(1, 2'd0, 8'h00, 2'd0, 8'hFF);
        look("R5", 32'h0500_0000, 1'b0, 3'd0, 1'b0);
        look("R5", 32'h0100_0000, 1'b1, 3'd0, 1'b0);
    endtask

    task automatic t_priority();
        set_bank(6, 2'd0, 8'h20, 2'd0, 8'h5F);
        wr(3'd4, 3'd0, 8'h61);
        look("R6", 32'h0250_0000, 1'b1, 3'd0, 1'b1);
        look("R7", 32'h0500_0000, 1'b1, 3'd6, 1'b0);
        look("R8", 32'h0700_0000, 1'b0, 3'd0, 1'b0);
        // enable bank 1 too: three-way overlap, still lowest wins
        wr(3'd4, 3'd0, 8'h63);
        look("R6", 32'h0250_0000, 1'b1, 3'd0, 1'b1);
        look("R7", 32'h0500_0000, 1'b1, 3'd1, 1'b1);
        // unused select codes write nothing
        wr(3'd5, 3'd0, 8'h00);
        wr(3'd7, 3'd6, 8'h00);
        look("R12", 32'h0250_0000, 1'b1, 3'd0, 1'b1);
    endtask

    task automatic t_latency();
        wr(3'd4, 3'd0, 8'h01);
        look("R9", 32'h0400_0000, 1'b0, 3'd0, 1'b0);
        @(negedge clk); addr_i = 32'h0000_1000;
        @(negedge clk);
        chk("R9", "hit after one edge", 32'(hit_o), 0);
        @(negedge clk);
        chk("R9", "hit after two edges", 32'(hit_o), 1);
    endtask

    task automatic t_cfg_err();
        set_bank(7, 2'd0, 8'h80, 2'd0, 8'h10);
        repeat (3) @(negedge clk);
        chk("R10", "err with inverted bank disabled", 32'(cfg_err_o), 0);
        wr(3'd4, 3'd0, 8'h81);
        repeat (2) @(negedge clk);
        chk("R10", "err set", 32'(cfg_err_o), 1);
        look("R10", 32'h0900_0000, 1'b0, 3'd0, 1'b0);
        wr(3'd0, 3'd3, 8'h44);
        repeat (2) @(negedge clk);
        chk("R11", "err kept over field write", 32'(cfg_err_o), 1);
        wr(3'd4, 3'd0, 8'h01);
        chk("R11", "err cleared by enable write", 32'(cfg_err_o), 0);
        repeat (3) @(negedge clk);
        chk("R11", "err stays clear", 32'(cfg_err_o), 0);
    endtask

    initial begin
        for (int b = 0; b < 8; b++) begin
            m_st[b] = '0; m_sx[b] = '0; m_nd[b] = '0; m_nx[b] = '0;
        end
        m_en = '0;
        repeat (3) @(negedge clk);
        chk("R1", "hit in reset", 32'(hit_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_range();
        t_ext_range();
        t_disabled();
        t_priority();
        t_latency();
        t_cfg_err();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule